// File: doc/BRIEF.md
# Serial Edit-Mode Fuse Array Model

This block models the device side of a programmable logic chip while it sits in its serial edit mode. A host drives a 6-bit row address, a read/write select, a serial data bit, a shift clock and an active-low strobe. The block answers on a single serial output. All pin-level signals are asynchronous to the block. They are sampled on a system clock through a synchroniser chain and then edge-detected.

Inside there is an array of fuse rows, a signature row, an architecture control word and a one-bit security flag. One shift register serves both directions. In write mode the host shifts a row's worth of bits in and then pulses the strobe to commit them to the addressed row. In read mode the strobe pulse loads the addressed row into the shift register, and shift-clock edges then walk its bits out. A strobe in write mode at the top address erases the whole array.

Top module: `pld_edit_array`

## Requirements
- R1: After reset every fuse row, the signature and the control word hold the erased value (all ones by default) and the security flag is clear. The shift register is zero, so `sdout` is 0.
- R2: Each rising edge of `sclk` shifts the register one place toward bit 0 and puts `sdin` into bit W-1, where W is the width of the currently addressed row. Bits at W and above are cleared. W is 82 at address 60, 1 at address 61, and 64 everywhere else. After W shifts, the first bit shifted in sits at bit 0 (first in, least significant).
- R3: With `wr_sel` high, a completed strobe pulse stores the shift register's low W bits into the addressed fuse row, signature row, control word or security flag (bit 0).
- R4: With `wr_sel` low, a completed strobe pulse copies the addressed row, zero-extended, into the shift register. `sdout` always shows register bit 0, so row bit 0 appears first and each later `sclk` rise presents the next bit. A read never changes the array.
- R5: A completed strobe pulse with `wr_sel` high at address 63 sets all fuse rows, the signature and the control word to the erased value and clears the security flag.
- R6: While the security flag is set, reads of fuse rows return all zeros. The signature row and the control word still read back their contents.
- R7: Addresses between the signature row and 60, and address 62, ignore writes and read back as zeros. Address 63 also reads as zeros.
- R8: A strobe action happens only when the synchronised strobe rises. Holding the strobe low does nothing. With SYNC_STAGES=2, `sdout` reflects a read load in the third clock after the strobe pin rises.
- R9: The fuse row count is a parameter. Rows 0 to FUSE_ROWS-1 are fuse rows and the signature row sits at address FUSE_ROWS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_addr | input | 6 | Row address pins |
| wr_sel | input | 1 | High selects write, low selects read |
| sdin | input | 1 | Serial data in |
| sclk | input | 1 | Shift clock pin, acts on its rising edge |
| strobe_n | input | 1 | Active-low strobe, acts when it returns high |
| sdout | output | 1 | Serial data out, bit 0 of the shift register |

## Verification
The bench builds the block with FUSE_ROWS=40, the wider variant, and the default SYNC_STAGES=2 and 82-bit control word. This makes rows 32 to 39 fuse rows and moves the signature row to address 40, so the boundary between the last fuse row and the signature can be written and read back. The two-stage synchroniser fixes the strobe-to-output latency at three clocks, which the bench checks edge by edge. The control-word row exercises the widest shift length, and the security row exercises the single-bit length.

// File: rtl/pld_edit_pkg.sv
package pld_edit_pkg;
  localparam int ADDR_W = 6;

  typedef enum logic [2:0] {
    RK_FUSE  = 3'd0,
    RK_SIG   = 3'd1,
    RK_CW    = 3'd2,
    RK_SEC   = 3'd3,
    RK_ERASE = 3'd4,
    RK_RSVD  = 3'd5
  } row_kind_e;

  // Decode a row address into its kind; fuse rows start at 0, signature follows them.
  function automatic row_kind_e classify_row(logic [ADDR_W-1:0] a, int fuse_rows,
                                             int cw_row, int sec_row, int erase_row);
    int ai;
    ai = int'(a);
    if (ai < fuse_rows)       return RK_FUSE;
    else if (ai == fuse_rows) return RK_SIG;
    else if (ai == cw_row)    return RK_CW;
    else if (ai == sec_row)   return RK_SEC;
    else if (ai == erase_row) return RK_ERASE;
    else                      return RK_RSVD;
  endfunction

  // Number of shift clocks a row of this kind takes.
  function automatic int row_bits(row_kind_e k, int row_w, int cw_w);
    case (k)
      RK_CW:   return cw_w;
      RK_SEC:  return 1;
      default: return row_w;
    endcase
  endfunction
endpackage

// File: rtl/pld_pin_sync.sv
module pld_pin_sync #(
  parameter int           W       = 10,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pld_edit_ctrl.sv
module pld_edit_ctrl
  import pld_edit_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FUSE_ROWS   = 32,
  parameter int ROW_W       = 64,
  parameter int CW_W        = 82,
  parameter int CW_ROW      = 60,
  parameter int SEC_ROW     = 61,
  parameter int ERASE_ROW   = 63,
  parameter int CNT_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] row_addr,
  input  logic              wr_sel,
  input  logic              sdin,
  input  logic              sclk,
  input  logic              strobe_n,
  output logic [ADDR_W-1:0] addr_s,
  output logic              sdin_s,
  output row_kind_e         kind_o,
  output logic [CNT_W-1:0]  width_o,
  output logic              sclk_rise_o,
  output logic              strobe_done_o,
  output logic              do_write_o,
  output logic              do_read_o,
  output logic              do_erase_o
);
  localparam int PW = ADDR_W + 4;
  localparam logic [PW-1:0] PIN_RST = PW'(1);

  logic [PW-1:0] pins_s;
  logic          wr_s, sclk_s, strb_s;
  logic          sclk_prev, strb_prev;

  pld_pin_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({row_addr, wr_sel, sdin, sclk, strobe_n}),
    .q_o   (pins_s)
  );

  assign {addr_s, wr_s, sdin_s, sclk_s, strb_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      strb_prev <= 1'b1;
    end else begin
      sclk_prev <= sclk_s;
      strb_prev <= strb_s;
    end
  end

  assign kind_o        = classify_row(addr_s, FUSE_ROWS, CW_ROW, SEC_ROW, ERASE_ROW);
  assign width_o       = CNT_W'(row_bits(kind_o, ROW_W, CW_W));
  assign sclk_rise_o   = sclk_s & ~sclk_prev;
  assign strobe_done_o = strb_s & ~strb_prev;
  assign do_erase_o    = strobe_done_o & wr_s & (kind_o == RK_ERASE);
  assign do_write_o    = strobe_done_o & wr_s & (kind_o != RK_ERASE);
  assign do_read_o     = strobe_done_o & ~wr_s;
endmodule

// File: rtl/pld_row_store.sv
module pld_row_store
  import pld_edit_pkg::*;
#(
  parameter int   FUSE_ROWS = 32,
  parameter int   ROW_W     = 64,
  parameter int   CW_W      = 82,
  parameter int   SR_W      = 82,
  parameter logic ERASE_VAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  row_kind_e         kind_i,
  input  logic              wr_en_i,
  input  logic              erase_en_i,
  input  logic [SR_W-1:0]   wr_data_i,
  output logic [SR_W-1:0]   rd_data_o,
  output logic              sec_o
);
  localparam int FIDX_W = (FUSE_ROWS > 1) ? $clog2(FUSE_ROWS) : 1;
  localparam logic [ROW_W-1:0] ROW_ERASED = {ROW_W{ERASE_VAL}};
  localparam logic [CW_W-1:0]  CW_ERASED  = {CW_W{ERASE_VAL}};

  logic [ROW_W-1:0] fuse_rd [FUSE_ROWS];
  logic [ROW_W-1:0] sig_q;
  logic [CW_W-1:0]  cw_q;
  logic             sec_q;
  logic [FIDX_W-1:0] fidx;

  assign fidx = addr_i[FIDX_W-1:0];

  for (genvar g = 0; g < FUSE_ROWS; g++) begin : g_row
    logic [ROW_W-1:0] q;
    logic             hit;
    assign hit = wr_en_i && (kind_i == RK_FUSE) && (int'(fidx) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= ROW_ERASED;
      else if (erase_en_i) q <= ROW_ERASED;
      else if (hit)        q <= wr_data_i[ROW_W-1:0];
    end
    assign fuse_rd[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= ROW_ERASED;
      cw_q  <= CW_ERASED;
      sec_q <= 1'b0;
    end else if (erase_en_i) begin
      sig_q <= ROW_ERASED;
      cw_q  <= CW_ERASED;
      sec_q <= 1'b0;
    end else if (wr_en_i) begin
      case (kind_i)
        RK_SIG:  sig_q <= wr_data_i[ROW_W-1:0];
        RK_CW:   cw_q  <= wr_data_i[CW_W-1:0];
        RK_SEC:  sec_q <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (kind_i)
      RK_FUSE: rd_data_o = sec_q ? '0 : SR_W'(fuse_rd[fidx]);
      RK_SIG:  rd_data_o = SR_W'(sig_q);
      RK_CW:   rd_data_o = SR_W'(cw_q);
      RK_SEC:  rd_data_o = SR_W'(sec_q);
      default: rd_data_o = '0;
    endcase
  end

  assign sec_o = sec_q;
endmodule

// File: rtl/pld_shift_path.sv
module pld_shift_path #(
  parameter int SR_W  = 82,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en_i,
  input  logic             shift_bit_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             load_en_i,
  input  logic [SR_W-1:0]  load_data_i,
  output logic [SR_W-1:0]  sr_o,
  output logic             sdout_o
);
  logic [SR_W-1:0] sr_q;

  // One step toward bit 0; the new bit enters at the top of the active row width.
  function automatic logic [SR_W-1:0] shift_step(logic [SR_W-1:0] cur, logic b,
                                                 logic [CNT_W-1:0] w);
    logic [SR_W-1:0] n;
    n = cur >> 1;
    for (int i = 0; i < SR_W; i++) begin
      if (i == int'(w) - 1)   n[i] = b;
      else if (i >= int'(w))  n[i] = 1'b0;
    end
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr_q <= '0;
    else if (load_en_i)  sr_q <= load_data_i;
    else if (shift_en_i) sr_q <= shift_step(sr_q, shift_bit_i, width_i);
  end

  assign sr_o    = sr_q;
  assign sdout_o = sr_q[0];
endmodule

// File: rtl/pld_edit_array.sv
module pld_edit_array
  import pld_edit_pkg::*;
#(
  parameter int   FUSE_ROWS   = 32,
  parameter int   ROW_W       = 64,
  parameter int   CW_W        = 82,
  parameter int   CW_ROW      = 60,
  parameter int   SEC_ROW     = 61,
  parameter int   ERASE_ROW   = 63,
  parameter int   SYNC_STAGES = 2,
  parameter logic ERASE_VAL   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] row_addr,
  input  logic       wr_sel,
  input  logic       sdin,
  input  logic       sclk,
  input  logic       strobe_n,
  output logic       sdout
);
  localparam int SR_W  = (CW_W > ROW_W) ? CW_W : ROW_W;
  localparam int CNT_W = $clog2(SR_W + 1);

  logic [ADDR_W-1:0] addr_s;
  logic              sdin_s;
  row_kind_e         kind;
  logic [CNT_W-1:0]  width;
  logic              sclk_rise, strobe_done;
  logic              do_write, do_read, do_erase;
  logic [SR_W-1:0]   sr_q, rd_data;
  logic              sec_q;

  pld_edit_ctrl #(
    .SYNC_STAGES (SYNC_STAGES), .FUSE_ROWS (FUSE_ROWS), .ROW_W (ROW_W),
    .CW_W (CW_W), .CW_ROW (CW_ROW), .SEC_ROW (SEC_ROW),
    .ERASE_ROW (ERASE_ROW), .CNT_W (CNT_W)
  ) u_ctrl (
    .clk (clk), .rst_n (rst_n), .row_addr (row_addr), .wr_sel (wr_sel),
    .sdin (sdin), .sclk (sclk), .strobe_n (strobe_n),
    .addr_s (addr_s), .sdin_s (sdin_s), .kind_o (kind), .width_o (width),
    .sclk_rise_o (sclk_rise), .strobe_done_o (strobe_done),
    .do_write_o (do_write), .do_read_o (do_read), .do_erase_o (do_erase)
  );

  pld_row_store #(
    .FUSE_ROWS (FUSE_ROWS), .ROW_W (ROW_W), .CW_W (CW_W),
    .SR_W (SR_W), .ERASE_VAL (ERASE_VAL)
  ) u_store (
    .clk (clk), .rst_n (rst_n), .addr_i (addr_s), .kind_i (kind),
    .wr_en_i (do_write), .erase_en_i (do_erase), .wr_data_i (sr_q),
    .rd_data_o (rd_data), .sec_o (sec_q)
  );

  pld_shift_path #(.SR_W (SR_W), .CNT_W (CNT_W)) u_shift (
    .clk (clk), .rst_n (rst_n), .shift_en_i (sclk_rise), .shift_bit_i (sdin_s),
    .width_i (width), .load_en_i (do_read), .load_data_i (rd_data),
    .sr_o (sr_q), .sdout_o (sdout)
  );
endmodule

// File: rtl/pld_edit_array_chk.sv
module pld_edit_array_chk
  import pld_edit_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      sclk_rise,
  input logic      do_write,
  input logic      do_read,
  input logic      do_erase,
  input row_kind_e kind,
  input logic      rd_bit0,
  input logic      sec_q,
  input logic      sdout
);
  // R2: the serial output moves only after a shift edge or a read load
  assert_sdout_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(sclk_rise || do_read));

  // R4: a read load puts row bit 0 on the serial output next cycle
  assert_read_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_read |=> (sdout == $past(rd_bit0)));

  // R5: bulk erase leaves the security flag clear
  assert_erase_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_erase |=> !sec_q);

  // R6: a secured fuse read yields a zero first bit
  assert_secure_fuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_read && kind == RK_FUSE && sec_q) |=> !sdout);

  // R8: one strobe completion triggers at most one kind of action
  assert_one_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_write, do_read, do_erase}));
endmodule

bind pld_edit_array pld_edit_array_chk u_chk (
  .clk (clk), .rst_n (rst_n), .sclk_rise (sclk_rise), .do_write (do_write),
  .do_read (do_read), .do_erase (do_erase), .kind (kind),
  .rd_bit0 (rd_data[0]), .sec_q (sec_q), .sdout (sdout)
);

// File: tb/pld_edit_array_bench.sv
module pld_edit_array_bench;
  localparam int NFUSE = 40;
  localparam int DLY   = 2;

  typedef struct packed {
    logic [5:0] a;
    logic       w;
    logic       d;
    logic       c;
    logic       s;
  } pins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] addr_i = '0;
  logic wr_i = 1'b0, sdin_i = 1'b0, sclk_i = 1'b0, strb_i = 1'b1;
  logic sdout;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pld_edit_array #(.FUSE_ROWS (NFUSE), .SYNC_STAGES (DLY)) u_pld_edit_array (
    .clk (clk), .rst_n (rst_n), .row_addr (addr_i), .wr_sel (wr_i),
    .sdin (sdin_i), .sclk (sclk_i), .strobe_n (strb_i), .sdout (sdout)
  );

  // ---------------- behavioural reference model ----------------
  bit [63:0] m_fuse [NFUSE];
  bit [63:0] m_sig;
  bit [81:0] m_cw;
  bit        m_sec;
  bit [81:0] m_sr;
  pins_t     hist [$];

  function automatic int m_width(int a);
    if (a == 60) return 82;
    if (a == 61) return 1;
    return 64;
  endfunction

  function automatic bit [81:0] m_read(int a);
    if (a < NFUSE)  return m_sec ? 82'd0 : {18'd0, m_fuse[a]};
    if (a == NFUSE) return {18'd0, m_sig};
    if (a == 60)    return m_cw;
    if (a == 61)    return {81'd0, m_sec};
    return 82'd0;
  endfunction

  task automatic m_erase();
    foreach (m_fuse[i]) m_fuse[i] = '1;
    m_sig = '1; m_cw = '1; m_sec = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_erase();
      m_sr = '0;
      hist.delete();
      for (int i = 0; i < DLY + 2; i++) hist.push_back(pins_t'(10'd1));
    end else begin
      pins_t cur, prv, dump;
      int a, w;
      hist.push_front({addr_i, wr_i, sdin_i, sclk_i, strb_i});
      dump = hist.pop_back();
      cur = hist[DLY]; prv = hist[DLY+1];
      a = int'(cur.a); w = m_width(a);
      if (cur.s && !prv.s && cur.w) begin
        if (a < NFUSE)       m_fuse[a] = m_sr[63:0];
        else if (a == NFUSE) m_sig = m_sr[63:0];
        else if (a == 60)    m_cw = m_sr;
        else if (a == 61)    m_sec = m_sr[0];
        else if (a == 63)    m_erase();
      end
      if (cur.c && !prv.c) begin
        m_sr = m_sr >> 1;
        m_sr[w-1] = cur.d;
        for (int i = w; i < 82; i++) m_sr[i] = 1'b0;
      end
      if (cur.s && !prv.s && !cur.w) m_sr = m_read(a);
      checks++;
      if (sdout !== m_sr[0]) begin
        failures++;
        $display("FAIL R4 lockstep sdout actual=%0b expected=%0b at %0t", sdout, m_sr[0], $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(string req, logic [81:0] act, logic [81:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe_pulse();
    strb_i = 1'b0; tick(4);
    strb_i = 1'b1; tick(6);
  endtask

  task automatic write_row(int a, logic [81:0] data);
    int w;
    w = m_width(a);
    wr_i = 1'b1; addr_i = 6'(a); tick(4);
    for (int i = 0; i < w; i++) begin
      sdin_i = data[i]; tick(2);
      sclk_i = 1'b1; tick(4);
      sclk_i = 1'b0; tick(2);
    end
    strobe_pulse();
  endtask

  task automatic read_row(int a, output logic [81:0] q);
    int w;
    w = m_width(a);
    q = '0;
    wr_i = 1'b0; addr_i = 6'(a); tick(4);
    strobe_pulse();
    for (int i = 0; i < w; i++) begin
      q[i] = sdout;
      sclk_i = 1'b1; tick(6);
      sclk_i = 1'b0; tick(4);
    end
  endtask

  localparam logic [81:0] PAT_A = {18'd0, 64'hA5C3_0F96_1234_5679};
  localparam logic [81:0] PAT_B = {18'd0, 64'h8000_0000_0000_0003};
  localparam logic [81:0] PAT_C = {18'd0, 64'h0123_4567_89AB_CDEF};
  localparam logic [81:0] PAT_D = {18'h2AB3C, 64'hDEAD_BEEF_0BAD_F00D};
  localparam logic [81:0] ONES64 = {18'd0, {64{1'b1}}};

  initial begin
    logic [81:0] q;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    check("R1 sdout after reset", {81'd0, sdout}, 82'd0);
    read_row(5, q);  check("R1 fuse row erased at reset", q, ONES64);
    read_row(61, q); check("R1 security clear at reset", q, 82'd0);

    write_row(3, PAT_A);
    read_row(3, q);  check("R3 fuse row 3 write/read", q, PAT_A);
    read_row(3, q);  check("R4 second read unchanged", q, PAT_A);
    write_row(NFUSE - 1, PAT_B);
    read_row(NFUSE - 1, q); check("R9 last fuse row 39", q, PAT_B);
    write_row(NFUSE, PAT_C);
    read_row(NFUSE, q); check("R9 signature at row 40", q, PAT_C);
    read_row(3, q);  check("R3 row 3 untouched by neighbours", q, PAT_A);
    write_row(60, PAT_D);
    read_row(60, q); check("R2 82-bit control word", q, PAT_D);

    write_row(45, PAT_C);
    read_row(45, q); check("R7 reserved row 45 reads zero", q, 82'd0);
    read_row(62, q); check("R7 reserved row 62 reads zero", q, 82'd0);
    read_row(63, q); check("R7 erase row reads zero", q, 82'd0);

    // R8: strobe latency and low-level hold; shift register holds PAT_A with bit0 = 1
    write_row(7, PAT_A);
    wr_i = 1'b0; addr_i = 6'd45; tick(4);
    strb_i = 1'b0; tick(10);
    check("R8 strobe held low has no effect", {81'd0, sdout}, 82'd1);
    strb_i = 1'b1; tick(2);
    check("R8 no load two clocks after rise", {81'd0, sdout}, 82'd1);
    tick(1);
    check("R8 load on third clock after rise", {81'd0, sdout}, 82'd0);
    tick(4);

    write_row(61, 82'd1);
    read_row(61, q); check("R3 security flag set", q, 82'd1);
    read_row(3, q);  check("R6 secured fuse row reads zero", q, 82'd0);
    read_row(NFUSE, q); check("R6 signature readable while secured", q, PAT_C);
    read_row(60, q); check("R6 control word readable while secured", q, PAT_D);

    write_row(63, 82'd0);
    read_row(61, q); check("R5 erase clears security", q, 82'd0);
    read_row(3, q);  check("R5 erase fuse row 3", q, ONES64);
    read_row(NFUSE - 1, q); check("R5 erase fuse row 39", q, ONES64);
    read_row(NFUSE, q); check("R5 erase signature", q, ONES64);
    read_row(60, q); check("R5 erase control word", q, {82{1'b1}});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule